// File: doc/BRIEF.md
# Dual-Mode SPI Read Front End

This block is the serial slave side of a small SPI flash model, limited to reads. A host selects it with an active-low chip select and sends an 8-bit command on SIO0. The block then takes a 24-bit start address, counts the dummy clocks the command needs, and streams bytes back. The stream is one bit per clock on SIO1, or two bits per clock on SIO1 and SIO0. Bytes come from an internal byte-read port, addressed by a 19-bit pointer that steps after every byte and wraps at the top of the space.

The serial pins are oversampled by the block's own clock. Every SCK edge is found after a short synchronizer, so the host's clock must stay at each level for at least four system clocks. A hold input pauses a transfer without ending it. Raising chip select ends a transfer at any point. The two data pins are not bidirectional ports here: the block drives a value and an output enable for each pin, and the pad ring combines them.

Top module: `dual_spi_read_fe`

## Requirements
- R1: After reset, and whenever chip select is high, both output enables are 0.
- R2: The first 8 rising SCK edges of a frame shift a command MSB first from SIO0. A command other than 03h, 0Bh, 3Bh or BBh drives no pin and makes no memory request for the rest of the frame.
- R3: Command 03h takes 24 address bits on SIO0 MSB first, with no dummy clocks. From the first falling SCK edge after the last address bit, data is driven on SIO1 MSB first with output enable 2'b10 (bit 1 is SIO1). SIO0 is never driven on its own.
- R4: Command 0Bh behaves like 03h but inserts 8 dummy clocks between the address and the data.
- R5: Command 3Bh takes its address and 8 dummy clocks on SIO0. Data then flows two bits per clock with output enable 2'b11: SIO1 carries bits 7, 5, 3, 1 and SIO0 carries bits 6, 4, 2, 0.
- R6: Command BBh takes the address two bits per clock, with SIO1 carrying the odd bits (A23 first) and SIO0 the even bits (A22 first). After 4 dummy clocks, data follows in the same pairing as R5. Both pins stay released until the first falling edge of the data phase.
- R7: The pointer uses address bits 18..0 and ignores bits 23..19. It advances by one for each byte and wraps from 7FFFFh to 00000h.
- R8: SCK idling low (mode 0) and SCK idling high (mode 3) both work. A falling edge before any data is due has no effect.
- R9: Hold begins when the hold input falls while SCK is low and ends when it rises while SCK is low. While held, SCK edges are ignored, both output enables are 0, and the stream resumes with the next bit afterwards.
- R10: A rising chip select ends the command in any phase, hold included. The next frame starts with a fresh command decode, and no memory request is made while chip select is high.
- R11: The memory port returns data on the cycle after a request. The block makes exactly one request when the address completes and one more at the start of every byte sent, always to the pointer's next value, and never on two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_hold_n | input | 1 | Active-low hold request |
| sio_in | input | 2 | Sampled pin levels, bit 1 = SIO1, bit 0 = SIO0 |
| sio_out | output | 2 | Values to drive on SIO1 and SIO0 |
| sio_oe | output | 2 | Output enables for SIO1 and SIO0 |
| mem_rd_req | output | 1 | Byte read request to the array |
| mem_rd_addr | output | 19 | Byte address of the request |
| mem_rd_data | input | 8 | Read byte, valid the cycle after the request |

## Verification
The assertions check on every cycle that the pins are released while deselected or held, that SIO0 is never driven without SIO1, and that read requests are isolated pulses. They also check that the addresses of successive requests in a frame step by exactly one, modulo the pointer width. Only the bench's transfers can show that each command's bit pairing, dummy length and first data edge are right, and that the byte stream matches a reference array across the wrap point. The same goes for hold resuming on the correct bit, an aborted hold leaving the next frame clean, and an unknown command staying silent.

// File: rtl/spi_fe_pkg.sv
// Shared constants, command encodings and the per-command configuration
// record for the dual-mode SPI read front end.
package spi_fe_pkg;

    localparam int OPC_BITS  = 8;
    localparam int ADDR_BITS = 24;
    localparam int DATA_W    = 8;
    localparam int CNT_W     = $clog2(ADDR_BITS);

    localparam logic [OPC_BITS-1:0] CMD_READ      = 8'h03;
    localparam logic [OPC_BITS-1:0] CMD_FAST      = 8'h0B;
    localparam logic [OPC_BITS-1:0] CMD_DUAL_OUT  = 8'h3B;
    localparam logic [OPC_BITS-1:0] CMD_DUAL_IO   = 8'hBB;

    localparam logic [3:0] DUMMY_SINGLE = 4'(DATA_W);
    localparam logic [3:0] DUMMY_DUAL   = 4'(DATA_W / 2);

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR,
        PH_DUMMY,
        PH_DATA,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic       valid;
        logic       addr_dual;
        logic       data_dual;
        logic [3:0] dummy_clks;
    } cmd_cfg_t;

    // Map a command byte to its address width, data width and dummy length.
    function automatic cmd_cfg_t decode_cmd(input logic [OPC_BITS-1:0] opc);
        cmd_cfg_t c;
        c = '0;
        case (opc)
            CMD_READ: begin
                c.valid = 1'b1;
            end
            CMD_FAST: begin
                c.valid      = 1'b1;
                c.dummy_clks = DUMMY_SINGLE;
            end
            CMD_DUAL_OUT: begin
                c.valid      = 1'b1;
                c.data_dual  = 1'b1;
                c.dummy_clks = DUMMY_SINGLE;
            end
            CMD_DUAL_IO: begin
                c.valid      = 1'b1;
                c.addr_dual  = 1'b1;
                c.data_dual  = 1'b1;
                c.dummy_clks = DUMMY_DUAL;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/spi_fe_sync.sv
// Pin synchronizer and edge finder.
// Brings SCK, chip select, hold and both data pins into the clk domain
// through one shared register chain, so the pins keep their relative
// timing. Reports qualified SCK edges and the hold state.
// Assumes each SCK level lasts at least SYNC_STAGES + 2 clk cycles.
module spi_fe_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_sck,
    input  logic       spi_cs_n,
    input  logic       spi_hold_n,
    input  logic [1:0] sio_in,
    output logic       cs_act,
    output logic       hold_act,
    output logic       sck_rise,
    output logic       sck_fall,
    output logic [1:0] sio_s
);
    localparam int NSIG = 5;
    localparam logic [NSIG-1:0] PIN_IDLE = 5'b0_1_1_00;

    logic [SYNC_STAGES-1:0][NSIG-1:0] stage;
    logic [NSIG-1:0] synced;
    logic s_sck, s_cs_n, s_hold_n;
    logic sck_d, hold_d, hold_q, live;

    // Shift the raw pins through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) stage[i] <= PIN_IDLE;
        end else begin
            stage[0] <= {spi_sck, spi_cs_n, spi_hold_n, sio_in};
            for (int i = 1; i < SYNC_STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign synced   = stage[SYNC_STAGES-1];
    assign s_sck    = synced[4];
    assign s_cs_n   = synced[3];
    assign s_hold_n = synced[2];
    assign sio_s    = synced[1:0];

    // Remember previous levels and track hold entry and exit at SCK low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d  <= 1'b0;
            hold_d <= 1'b1;
            hold_q <= 1'b0;
        end else begin
            sck_d  <= s_sck;
            hold_d <= s_hold_n;
            if (s_cs_n)
                hold_q <= 1'b0;
            else if (!s_sck && hold_d && !s_hold_n)
                hold_q <= 1'b1;
            else if (!s_sck && !hold_d && s_hold_n)
                hold_q <= 1'b0;
        end
    end

    assign cs_act   = ~s_cs_n;
    assign hold_act = hold_q;
    assign live     = cs_act & ~hold_q;
    assign sck_rise = live &  s_sck & ~sck_d;
    assign sck_fall = live & ~s_sck &  sck_d;

endmodule

// File: rtl/spi_fe_seq.sv
// Command sequencer.
// Counts rising SCK edges through command, address and dummy phases,
// decodes the command and assembles the start address one bit or one
// dibit per clock. Pulses addr_load once the address is complete.
// Only the low PTR_W address bits are kept; the rest shift out.
module spi_fe_seq
    import spi_fe_pkg::*;
#(
    parameter int PTR_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_act,
    input  logic             sck_rise,
    input  logic [1:0]       sio_s,
    output logic             in_data,
    output logic             data_dual,
    output logic             addr_load,
    output logic [PTR_W-1:0] load_addr
);
    localparam logic [CNT_W-1:0] CMD_LAST    = CNT_W'(OPC_BITS - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST_1 = CNT_W'(ADDR_BITS - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST_2 = CNT_W'(ADDR_BITS / 2 - 1);

    phase_e              phase;
    logic [CNT_W-1:0]    cnt;
    logic [OPC_BITS-2:0] cmd_sh;
    logic [OPC_BITS-1:0] cmd_next;
    logic [PTR_W-1:0]    addr_sh, addr_next;
    cmd_cfg_t            cfg, cfg_new;
    logic [CNT_W-1:0]    addr_last, dummy_last;

    // Next shift values and phase limits for the current command.
    always_comb begin
        cmd_next   = {cmd_sh, sio_s[0]};
        cfg_new    = decode_cmd(cmd_next);
        addr_next  = cfg.addr_dual ? {addr_sh[PTR_W-3:0], sio_s}
                                   : {addr_sh[PTR_W-2:0], sio_s[0]};
        addr_last  = cfg.addr_dual ? ADDR_LAST_2 : ADDR_LAST_1;
        dummy_last = CNT_W'(cfg.dummy_clks - 4'd1);
    end

    // Walk the phases on rising SCK edges; restart when deselected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_CMD;
            cnt       <= '0;
            cmd_sh    <= '0;
            addr_sh   <= '0;
            cfg       <= '0;
            addr_load <= 1'b0;
        end else begin
            addr_load <= 1'b0;
            if (!cs_act) begin
                phase <= PH_CMD;
                cnt   <= '0;
            end else if (sck_rise) begin
                case (phase)
                    PH_CMD: begin
                        cmd_sh <= cmd_next[OPC_BITS-2:0];
                        if (cnt == CMD_LAST) begin
                            cfg   <= cfg_new;
                            phase <= cfg_new.valid ? PH_ADDR : PH_SKIP;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_ADDR: begin
                        addr_sh <= addr_next;
                        if (cnt == addr_last) begin
                            addr_load <= 1'b1;
                            cnt       <= '0;
                            phase     <= (cfg.dummy_clks == 4'd0) ? PH_DATA : PH_DUMMY;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_DUMMY: begin
                        if (cnt == dummy_last) begin
                            cnt   <= '0;
                            phase <= PH_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign in_data   = (phase == PH_DATA);
    assign data_dual = cfg.data_dual;
    assign load_addr = addr_sh;

endmodule

// File: rtl/spi_fe_fetch.sv
// Read pointer and one-byte prefetch buffer.
// Loads the pointer when the address completes and requests a byte.
// Asks for the following byte each time a byte starts shifting out,
// so a full byte time is left for the array. The pointer wraps
// naturally at 2**PTR_W. Assumes a read latency of one clk cycle.
module spi_fe_fetch
    import spi_fe_pkg::*;
#(
    parameter int PTR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              addr_load,
    input  logic [PTR_W-1:0]  load_addr,
    input  logic              refill,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_rd_req,
    output logic [PTR_W-1:0]  mem_rd_addr,
    output logic [DATA_W-1:0] next_byte
);
    logic [PTR_W-1:0]  ptr;
    logic              req_q, cap_q;
    logic [DATA_W-1:0] nxt_q;

    // Issue requests, step the pointer and capture returned bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr   <= '0;
            req_q <= 1'b0;
            cap_q <= 1'b0;
            nxt_q <= '0;
        end else begin
            if (!cs_act) begin
                req_q <= 1'b0;
                cap_q <= 1'b0;
            end else begin
                req_q <= addr_load | refill;
                cap_q <= req_q;
            end
            if (addr_load)
                ptr <= load_addr;
            else if (req_q)
                ptr <= ptr + 1'b1;
            if (cap_q)
                nxt_q <= mem_rd_data;
        end
    end

    assign mem_rd_req  = req_q;
    assign mem_rd_addr = ptr;
    assign next_byte   = nxt_q;

endmodule

// File: rtl/spi_fe_tx.sv
// Output shifter and pin enables.
// On each falling SCK edge of the data phase, loads the prefetched byte
// at a byte boundary or shifts by one or two bits. Drives SIO1 (and
// SIO0 in dual mode) with enables that drop while held or deselected.
module spi_fe_tx
    import spi_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              hold_act,
    input  logic              in_data,
    input  logic              data_dual,
    input  logic              sck_fall,
    input  logic [DATA_W-1:0] next_byte,
    output logic              byte_start,
    output logic [1:0]        sio_out,
    output logic [1:0]        sio_oe
);
    localparam int POS_W = $clog2(DATA_W);
    localparam logic [POS_W-1:0] LAST_1 = POS_W'(DATA_W - 1);
    localparam logic [POS_W-1:0] LAST_2 = POS_W'(DATA_W / 2 - 1);

    logic [DATA_W-1:0] sh;
    logic [POS_W-1:0]  pos, pos_last;
    logic              en, data_fall;
    logic [1:0]        oe_q;

    assign data_fall  = sck_fall & in_data;
    assign byte_start = data_fall & (pos == '0);
    assign pos_last   = data_dual ? LAST_2 : LAST_1;

    // Load or shift the output byte and register the pin enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '0;
            pos  <= '0;
            en   <= 1'b0;
            oe_q <= 2'b00;
        end else begin
            if (!cs_act) begin
                pos <= '0;
                en  <= 1'b0;
            end else if (data_fall) begin
                en <= 1'b1;
                if (pos == '0)
                    sh <= next_byte;
                else
                    sh <= data_dual ? (sh << 2) : (sh << 1);
                pos <= (pos == pos_last) ? '0 : pos + 1'b1;
            end
            oe_q <= (cs_act && en && !hold_act) ? {1'b1, data_dual} : 2'b00;
        end
    end

    assign sio_out = {sh[DATA_W-1], data_dual & sh[DATA_W-2]};
    assign sio_oe  = oe_q;

endmodule

// File: rtl/dual_spi_read_fe.sv
// Dual-mode SPI read front end, top level.
// Joins the pin synchronizer, command sequencer, prefetching read
// pointer and output shifter. Handles commands 03h, 0Bh, 3Bh and BBh
// in SPI modes 0 and 3 with hold. Pins are exposed as value/enable pairs.
module dual_spi_read_fe
    import spi_fe_pkg::*;
#(
    parameter int PTR_W       = 19,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_hold_n,
    input  logic [1:0]        sio_in,
    output logic [1:0]        sio_out,
    output logic [1:0]        sio_oe,
    output logic              mem_rd_req,
    output logic [PTR_W-1:0]  mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data
);
    logic              cs_act, hold_act, sck_rise, sck_fall;
    logic [1:0]        sio_s;
    logic              in_data, data_dual, addr_load, byte_start;
    logic [PTR_W-1:0]  load_addr;
    logic [DATA_W-1:0] next_byte;

    spi_fe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_sck    (spi_sck),
        .spi_cs_n   (spi_cs_n),
        .spi_hold_n (spi_hold_n),
        .sio_in     (sio_in),
        .cs_act     (cs_act),
        .hold_act   (hold_act),
        .sck_rise   (sck_rise),
        .sck_fall   (sck_fall),
        .sio_s      (sio_s)
    );

    spi_fe_seq #(.PTR_W(PTR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .sck_rise  (sck_rise),
        .sio_s     (sio_s),
        .in_data   (in_data),
        .data_dual (data_dual),
        .addr_load (addr_load),
        .load_addr (load_addr)
    );

    spi_fe_fetch #(.PTR_W(PTR_W)) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_act      (cs_act),
        .addr_load   (addr_load),
        .load_addr   (load_addr),
        .refill      (byte_start),
        .mem_rd_data (mem_rd_data),
        .mem_rd_req  (mem_rd_req),
        .mem_rd_addr (mem_rd_addr),
        .next_byte   (next_byte)
    );

    spi_fe_tx u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_act     (cs_act),
        .hold_act   (hold_act),
        .in_data    (in_data),
        .data_dual  (data_dual),
        .sck_fall   (sck_fall),
        .next_byte  (next_byte),
        .byte_start (byte_start),
        .sio_out    (sio_out),
        .sio_oe     (sio_oe)
    );

endmodule

// File: rtl/spi_fe_checker.sv
// Protocol checker for the dual-mode SPI read front end, bound to the top.
// Watches pin enables against select and hold, request spacing, and the
// address step between successive requests of one frame.
module spi_fe_checker #(
    parameter int PTR_W = 19
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_act,
    input logic             hold_act,
    input logic [1:0]       sio_oe,
    input logic             mem_rd_req,
    input logic [PTR_W-1:0] mem_rd_addr
);
    logic [PTR_W-1:0] last_addr;
    logic             seen;

    // Remember the previous request address within the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_addr <= '0;
            seen      <= 1'b0;
        end else if (!cs_act) begin
            seen <= 1'b0;
        end else if (mem_rd_req) begin
            seen      <= 1'b1;
            last_addr <= mem_rd_addr;
        end
    end

    assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (sio_oe == 2'b00));

    assert_no_lone_sio0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sio_oe != 2'b01);

    assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && seen) |-> (mem_rd_addr == PTR_W'(last_addr + 1'b1)));

    assert_hold_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hold_act |=> (sio_oe == 2'b00));

    assert_idle_no_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !mem_rd_req);

    assert_req_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);

endmodule

bind dual_spi_read_fe spi_fe_checker #(.PTR_W(PTR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_act      (cs_act),
    .hold_act    (hold_act),
    .sio_oe      (sio_oe),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_addr (mem_rd_addr)
);

// File: tb/dual_spi_read_fe_tb.sv
// Bench: bit-banged SPI host against a behavioural byte array. Expected
// bytes, pin enables and request counts come from the requirements alone.
module dual_spi_read_fe_tb;
    localparam int HP = 10;   // clk cycles per SCK half period

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sck = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_hold_n = 1'b1;
    logic [1:0]  sio_in = 2'b00;
    logic [1:0]  sio_out, sio_oe;
    logic        mem_rd_req;
    logic [18:0] mem_rd_addr;
    logic [7:0]  mem_rd_data = 8'h00;
    int          req_cnt = 0;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    dual_spi_read_fe u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_hold_n(spi_hold_n), .sio_in(sio_in), .sio_out(sio_out),
        .sio_oe(sio_oe), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data)
    );

    function automatic logic [7:0] mem_val(input int a);
        int x;
        x = a & 32'h7FFFF;
        return 8'(x ^ (x >> 8) ^ ((x >> 16) * 29) ^ 8'h5A);
    endfunction

    // Reference array with one-cycle read latency, plus a request counter.
    always @(posedge clk) begin
        if (mem_rd_req) begin
            mem_rd_data <= mem_val(int'(mem_rd_addr));
            req_cnt     <= req_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One SCK period: fall, half low (optional hold), sample, rise, half high.
    // hmode 0 = none, 1 = hold and resume, 2 = hold then deselect.
    task automatic sck_cycle(input logic [1:0] din, input int hmode,
                             output logic [1:0] dout, output logic [1:0] doe);
        spi_sck = 1'b0;
        sio_in  = din;
        repeat (HP) @(negedge clk);
        if (hmode != 0) begin
            spi_hold_n = 1'b0;
            repeat (HP) @(negedge clk);
            check(sio_oe == 2'b00, "R9", "pins released in hold", sio_oe, 0);
            if (hmode == 2) begin
                spi_cs_n = 1'b1;
                repeat (HP) @(negedge clk);
                spi_hold_n = 1'b1;
                repeat (HP) @(negedge clk);
                dout = sio_out;
                doe  = sio_oe;
                return;
            end
            repeat (2) begin
                spi_sck = 1'b1;
                repeat (HP) @(negedge clk);
                spi_sck = 1'b0;
                repeat (HP) @(negedge clk);
            end
            spi_hold_n = 1'b1;
            repeat (HP) @(negedge clk);
        end
        dout = sio_out;
        doe  = sio_oe;
        spi_sck = 1'b1;
        repeat (HP) @(negedge clk);
    endtask

    task automatic run_read(input logic [7:0] opc, input logic [23:0] addr,
                            input int nbytes, input bit mode3, input int hold_byte,
                            input int hold_mode, input string tag);
        logic [1:0] d, o;
        bit   dual_a, dual_d;
        int   dummy, bpb, base, pre_bad, ptr;
        logic [1:0] exp_oe;
        dual_a = (opc == 8'hBB);
        dual_d = (opc == 8'h3B) || dual_a;
        dummy  = (opc == 8'h03) ? 0 : (dual_a ? 4 : 8);
        bpb    = dual_d ? 4 : 8;
        exp_oe = dual_d ? 2'b11 : 2'b10;
        ptr    = int'(addr[18:0]);
        pre_bad = 0;
        spi_sck = mode3;
        spi_hold_n = 1'b1;
        repeat (HP) @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (HP) @(negedge clk);
        for (int i = 7; i >= 0; i--) sck_cycle({1'b0, opc[i]}, 0, d, o);
        base = req_cnt;
        if (dual_a) begin
            for (int k = 11; k >= 0; k--) begin
                sck_cycle({addr[2*k+1], addr[2*k]}, 0, d, o);
                if (o != 2'b00) pre_bad++;
            end
        end else begin
            for (int i = 23; i >= 0; i--) begin
                sck_cycle({1'b0, addr[i]}, 0, d, o);
                if (o != 2'b00) pre_bad++;
            end
        end
        for (int i = 0; i < dummy; i++) begin
            sck_cycle(2'b00, 0, d, o);
            if (o != 2'b00) pre_bad++;
        end
        check(pre_bad == 0, tag, "pins driven before data phase", pre_bad, 0);
        for (int b = 0; b < nbytes; b++) begin
            logic [7:0] got, exp;
            bit oe_ok;
            got = 8'h00;
            oe_ok = 1'b1;
            exp = mem_val(ptr);
            for (int s = 0; s < bpb; s++) begin
                int hm;
                hm = (b == hold_byte && s == 2) ? hold_mode : 0;
                sck_cycle(2'b00, hm, d, o);
                if (hm == 2) begin
                    check(sio_oe == 2'b00, "R10", "pins after deselect in hold", sio_oe, 0);
                    repeat (HP) @(negedge clk);
                    return;
                end
                got = dual_d ? {got[5:0], d[1], d[0]} : {got[6:0], d[1]};
                if (o != exp_oe) oe_ok = 1'b0;
            end
            check(got == exp, tag, $sformatf("byte %0d at %05h", b, ptr), got, exp);
            check(oe_ok, tag, "output enables in data phase", o, exp_oe);
            ptr = (ptr + 1) & 32'h7FFFF;
        end
        check(req_cnt - base == nbytes + 1, "R11", "read requests in frame",
              req_cnt - base, nbytes + 1);
        if (!mode3) begin
            spi_sck = 1'b0;
            repeat (HP) @(negedge clk);
        end
        spi_cs_n = 1'b1;
        repeat (2 * HP) @(negedge clk);
        check(sio_oe == 2'b00, "R1", "pins released after frame", sio_oe, 0);
    endtask

    task automatic run_bad(input logic [7:0] opc);
        logic [1:0] d, o;
        int base, bad;
        bad = 0;
        spi_sck = 1'b0;
        repeat (HP) @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (HP) @(negedge clk);
        base = req_cnt;
        for (int i = 7; i >= 0; i--) sck_cycle({1'b0, opc[i]}, 0, d, o);
        for (int i = 0; i < 24; i++) begin
            sck_cycle(2'b11, 0, d, o);
            if (o != 2'b00) bad++;
        end
        check(bad == 0, "R2", "pins driven after unknown command", bad, 0);
        check(req_cnt == base, "R2", "requests after unknown command", req_cnt - base, 0);
        spi_sck = 1'b0;
        repeat (HP) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (2 * HP) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (10) @(negedge clk);
        check(sio_oe == 2'b00, "R1", "enables during reset", sio_oe, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check(sio_oe == 2'b00, "R1", "enables after reset", sio_oe, 0);
        check(req_cnt == 0, "R1", "requests after reset", req_cnt, 0);

        run_read(8'h03, 24'h001234, 5, 1'b0, -1, 0, "R3 R8");
        run_read(8'h0B, 24'h00ABC0, 4, 1'b1, -1, 0, "R4 R8");
        run_read(8'h3B, 24'h012345, 4, 1'b0, -1, 0, "R5");
        run_read(8'hBB, 24'h05A5A7, 4, 1'b1, -1, 0, "R6 R8");
        run_read(8'h03, 24'h07FFFE, 4, 1'b0, -1, 0, "R7");
        run_read(8'hBB, 24'h07FFFF, 3, 1'b0, -1, 0, "R7");
        run_read(8'h3B, 24'hF80005, 3, 1'b1, -1, 0, "R7");
        run_read(8'h03, 24'h020010, 3, 1'b0, 1, 1, "R9");
        run_read(8'hBB, 24'h030000, 3, 1'b1, 1, 1, "R9");
        run_read(8'h0B, 24'h040000, 3, 1'b0, 1, 2, "R10");
        run_bad(8'h05);
        run_read(8'h0B, 24'h000100, 2, 1'b0, -1, 0, "R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule